// File: doc/BRIEF.md
# Event-Counting Down Timer Channel

This block is a single down-counting timer channel whose count clock is a selected edge of an external event input instead of a divided clock. The raw event pin is brought into the module clock domain by a two-flop synchronizer. An optional glitch filter follows it, and then an edge detector that accepts rising, falling or both edges. The host writes a reload value and pulses a start strobe. The channel goes enabled, copies the reload value into the counter, and subtracts one for each accepted edge from then on.

When an edge arrives while the counter already reads zero, the channel raises a one-cycle terminal-count pulse and refills the counter from the reload register. A stop strobe disables the channel. The counter then freezes, and edges are ignored until the next start. A new reload value written while the channel runs only matters at the next start or the next terminal-count refill.

Top module: `evt_down_timer`

## Requirements
- R1: During synchronous reset and in the first cycle after it, `enable_o` is 0, `tc_o` is 0 and `count_o` equals `INIT_CNT` (default 16'hFFFF).
- R2: While `enable_o` is 0 and no start is applied, `count_o` does not change, whatever `evt_i` does.
- R3: A clock edge that sees `start_i`=1 and `stop_i`=0 makes `enable_o` 1 and loads `count_o` with the reload register value held before that edge. This also applies when the channel is already running, which restarts it.
- R4: With the filter off, a change on `evt_i` that is driven between clock edges and forms a valid edge decrements `count_o` by one at the third rising clock edge after the change. The first two edges leave it unchanged.
- R5: `edge_sel_i` picks the valid edge: 2'b00 selects rising edges only, 2'b01 falling edges only, and 2'b10 or 2'b11 both edges.
- R6: With `filt_en_i`=1, the decrement comes two clock edges later than in R4, at the fifth edge. A synchronized level that lasts only one clock is discarded. With the filter off, the same pulse counts as an edge.
- R7: A valid edge while enabled with `count_o`=0 raises `tc_o` for exactly one cycle and reloads `count_o` from the reload register in that same cycle.
- R8: `stop_i`=1 clears `enable_o` at the next edge. `count_o` keeps its value, and later edges do not change it.
- R9: When `start_i` and `stop_i` are both 1 at one edge, the stop wins: `enable_o` ends 0 and `count_o` is not loaded.
- R10: A write through `reload_we_i` does not change `count_o` by itself. The written value is what the next start or terminal-count refill loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe, wins over start |
| reload_we_i | input | 1 | Write enable for the reload register |
| reload_data_i | input | CNT_W | Reload value to write |
| filt_en_i | input | 1 | Enables the two-cycle glitch filter |
| edge_sel_i | input | 2 | Valid edge: 00 rise, 01 fall, 1x both |
| evt_i | input | 1 | Asynchronous event input |
| enable_o | output | 1 | Channel running |
| count_o | output | CNT_W | Current counter value |
| tc_o | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench measures the exact clock edge at which the count moves, with the filter both off and on. A synchronizer or filter with one stage too many or too few shifts that edge, and the bench catches the shift. It applies a one-cycle glitch in both filter settings. A filter that only delays the level, without requiring two matching samples, would count the glitch. It crosses zero with a reload value written mid-run, which exposes a design that loads the reload data straight from the bus or that keeps the terminal-count pulse high too long. It also strobes start and stop together, and pulses the event input while stopped, to show whether priority or gating is missing.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE     = 2'b00,
    EDGE_FALL     = 2'b01,
    EDGE_BOTH     = 2'b10,
    EDGE_BOTH_ALT = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/evt_sync_filter.sv
module evt_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;
  logic [FILT_LEN-1:0]    window;
  logic                   filt_q;
  logic                   agree;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign sync_o = sync_q[SYNC_STAGES-1];

  generate
    if (HIST_W == 1) begin : g_hist1
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= sync_o;
      end
    end else begin : g_histn
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[HIST_W-2:0], sync_o};
      end
    end
  endgenerate

  assign window = {hist_q, sync_o};
  assign agree  = (&window) | ~(|window);

  always_ff @(posedge clk) begin
    if (rst)        filt_q <= 1'b0;
    else if (agree) filt_q <= sync_o;
  end

  assign filt_o = filt_q;

  // R6
  filt_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> ($past(sync_o) == filt_q && $past(hist_q[0]) == filt_q));
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det
  import evt_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  output logic      edge_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      default:   edge_o = rise | fall;
    endcase
  end
endmodule

// File: rtl/evt_cnt_core.sv
module evt_cnt_core #(
  parameter int                 CNT_W    = 16,
  parameter logic [CNT_W-1:0]   INIT_CNT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_data_i,
  input  logic             edge_i,
  output logic             enable_o,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);
  logic             enable_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic             tc_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
      cnt_q    <= INIT_CNT;
      reload_q <= '0;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (reload_we_i) reload_q <= reload_data_i;
      if (stop_i) begin
        enable_q <= 1'b0;
      end else if (start_i) begin
        enable_q <= 1'b1;
        cnt_q    <= reload_q;
      end else if (enable_q && edge_i) begin
        if (at_zero) begin
          cnt_q <= reload_q;
          tc_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign enable_o = enable_q;
  assign count_o  = cnt_q;
  assign tc_o     = tc_q;

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i) |=> (enable_q && cnt_q == $past(reload_q)));
  // R9
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !enable_q);
  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> $stable(cnt_q));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable_q && !start_i) |=> $stable(cnt_q));
  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_q && edge_i && !start_i && !stop_i && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1) && !tc_q));
  // R7
  tc_reload_chk: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> ($past(cnt_q) == '0 && cnt_q == $past(reload_q) && $past(enable_q)));
endmodule

// File: rtl/evt_down_timer.sv
module evt_down_timer
  import evt_timer_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter logic [CNT_W-1:0] INIT_CNT    = '1,
  parameter int               SYNC_STAGES = 2,
  parameter int               FILT_LEN    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_data_i,
  input  logic             filt_en_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             evt_i,
  output logic             enable_o,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);
  logic sync_lvl, filt_lvl, sel_lvl, evt_edge;

  evt_sync_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filter (
    .clk   (clk),
    .rst   (rst),
    .raw_i (evt_i),
    .sync_o(sync_lvl),
    .filt_o(filt_lvl)
  );

  assign sel_lvl = filt_en_i ? filt_lvl : sync_lvl;

  evt_edge_det u_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (sel_lvl),
    .sel_i (edge_sel_e'(edge_sel_i)),
    .edge_o(evt_edge)
  );

  evt_cnt_core #(
    .CNT_W   (CNT_W),
    .INIT_CNT(INIT_CNT)
  ) u_core (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .reload_we_i  (reload_we_i),
    .reload_data_i(reload_data_i),
    .edge_i       (evt_edge),
    .enable_o     (enable_o),
    .count_o      (count_o),
    .tc_o         (tc_o)
  );
endmodule

// File: tb/evt_down_timer_bench.sv
module evt_down_timer_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, stop_i, reload_we_i, filt_en_i, evt_i;
  logic [15:0] reload_data_i;
  logic [1:0]  edge_sel_i;
  logic        enable_o, tc_o;
  logic [15:0] count_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  evt_down_timer u_evt_down_timer (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .reload_we_i(reload_we_i), .reload_data_i(reload_data_i),
    .filt_en_i(filt_en_i), .edge_sel_i(edge_sel_i), .evt_i(evt_i),
    .enable_o(enable_o), .count_o(count_o), .tc_o(tc_o)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        filt;
    logic [15:0] rld;
    logic [3:0]  npulse;
    logic [15:0] expect_cnt;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{2'b00, 1'b0, 16'd10,  4'd3, 16'd7},
    '{2'b01, 1'b0, 16'd10,  4'd3, 16'd7},
    '{2'b10, 1'b0, 16'd20,  4'd3, 16'd14},
    '{2'b00, 1'b1, 16'd5,   4'd2, 16'd3},
    '{2'b10, 1'b1, 16'd100, 4'd4, 16'd92},
    '{2'b11, 1'b0, 16'd9,   4'd4, 16'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reload(input logic [15:0] v);
    reload_we_i = 1'b1; reload_data_i = v;
    step(1);
    reload_we_i = 1'b0;
  endtask

  task automatic do_start();
    start_i = 1'b1; step(1); start_i = 1'b0;
  endtask

  task automatic do_stop();
    stop_i = 1'b1; step(1); stop_i = 1'b0;
  endtask

  task automatic pulse(input int hold);
    evt_i = 1'b1; step(hold);
    evt_i = 1'b0; step(hold);
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; stop_i = 1'b0; reload_we_i = 1'b0;
    reload_data_i = '0; filt_en_i = 1'b0; edge_sel_i = 2'b00; evt_i = 1'b0;
    step(3);
    chk("R1 enable in reset", enable_o, 0);
    chk("R1 count in reset", count_o, 16'hFFFF);
    rst = 1'b0;
    step(1);
    chk("R1 count after reset", count_o, 16'hFFFF);
    chk("R1 tc after reset", tc_o, 0);

    // R2: edges while stopped are ignored
    pulse(4); pulse(4);
    chk("R2 count held while stopped", count_o, 16'hFFFF);
    chk("R2 enable low while stopped", enable_o, 0);

    // Vector table: R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      edge_sel_i = VEC[i].sel;
      filt_en_i  = VEC[i].filt;
      evt_i      = 1'b0;
      step(8);
      write_reload(VEC[i].rld);
      do_start();
      chk("R3 vector load", count_o, {16'h0, VEC[i].rld});
      for (int p = 0; p < int'(VEC[i].npulse); p++) pulse(6);
      step(8);
      chk("R5 vector count", count_o, {16'h0, VEC[i].expect_cnt});
      do_stop();
    end

    // R4: unfiltered latency, rising select
    edge_sel_i = 2'b00; filt_en_i = 1'b0; step(4);
    write_reload(16'd50);
    do_start();
    evt_i = 1'b1; step(2);
    chk("R4 no change before third edge", count_o, 50);
    step(1);
    chk("R4 decrement at third edge", count_o, 49);
    evt_i = 1'b0; step(6);
    chk("R5 falling edge ignored in rise mode", count_o, 49);

    // R6: filtered latency
    filt_en_i = 1'b1; step(6);
    evt_i = 1'b1; step(4);
    chk("R6 no change before fifth edge", count_o, 49);
    step(1);
    chk("R6 decrement at fifth edge", count_o, 48);
    evt_i = 1'b0; step(6);
    // R6: one-cycle glitch discarded with filter
    evt_i = 1'b1; step(1); evt_i = 1'b0; step(8);
    chk("R6 glitch rejected by filter", count_o, 48);
    // without filter the same glitch counts
    filt_en_i = 1'b0; step(4);
    evt_i = 1'b1; step(1); evt_i = 1'b0; step(8);
    chk("R6 glitch counted without filter", count_o, 47);

    // R10 and R7: reload changed mid-run, terminal count
    do_stop();
    write_reload(16'd2);
    do_start();
    chk("R3 load value 2", count_o, 2);
    write_reload(16'd7);
    chk("R10 write leaves count", count_o, 2);
    pulse(5); pulse(5);
    chk("R7 reached zero", count_o, 0);
    chk("R7 no tc yet", tc_o, 0);
    evt_i = 1'b1; step(3);
    chk("R7 tc pulse high", tc_o, 1);
    chk("R10 tc reload uses new value", count_o, 7);
    step(1);
    chk("R7 tc one cycle", tc_o, 0);
    evt_i = 1'b0; step(6);

    // R3 restart while running
    pulse(5);
    chk("R3 running count", count_o, 6);
    write_reload(16'd12);
    do_start();
    chk("R3 restart reload", count_o, 12);
    chk("R3 enable set", enable_o, 1);

    // R8 stop freezes
    do_stop();
    chk("R8 enable cleared", enable_o, 0);
    pulse(5); pulse(5);
    chk("R8 count frozen", count_o, 12);

    // R9 start and stop together
    write_reload(16'd33);
    start_i = 1'b1; stop_i = 1'b1; step(1);
    start_i = 1'b0; stop_i = 1'b0;
    chk("R9 stop wins enable", enable_o, 0);
    chk("R9 stop wins count", count_o, 12);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule